// File: doc/BRIEF.md
# Qualified Sticky Event Sense and Output Enable Register

This block gives a control bus a small user register that both watches and drives external pins. Each of a set of external sense inputs is brought into the clock domain through a multi-flop synchronizer. It then passes a minimum-width qualifier: the input must stay high for a parameterised number of consecutive clock cycles before it counts as an event. A qualified event sets a sticky status bit. That bit stays set after the pin drops and clears only when software writes a one to it. While any status bit is set, the block drives an interrupt request.

The same register holds one enable bit per channel. Each enable bit drives an external enable pin directly. A second bus address holds a one-bit run/stop mode flag. An active-low asynchronous reset clears every bit, so the block leaves reset in stop mode with all outputs low.

The bus is a simple synchronous write port with a combinational read path. A qualified input that is still held high after its bit was cleared does not set the bit again. The input must first go low and then qualify again.

Top module: `sense_latch_regs`

## Requirements
- R1: While `rst_n` is low, every register bit is zero: reads of both addresses return 0, `irq` is 0 and `ext_enable` is 0. The mode bit therefore resets to 0, which means stop.
- R2: Status bit i (user register at address 0, bit i) is set only after `ext_sense[i]` has been high at QUAL_CYC consecutive sampling edges (default 4). A pulse one cycle shorter leaves the bit at 0.
- R3: A set status bit stays at 1 after its sense input returns low.
- R4: A write to address 0 clears status bit i when data bit i is 1 and leaves it unchanged when data bit i is 0.
- R5: If qualification and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: An input held high after its bit was cleared does not set the bit again. After the input goes low and then qualifies again, the bit is set.
- R7: `irq` is 1 exactly when at least one status bit is 1.
- R8: A write to address 0 loads enable bit i from data bit N_CH+i (bits 2 and 3 by default). `ext_enable[i]` equals that bit from the cycle after the write, and the bit reads back at the same position.
- R9: Address 1, bit 0 is the mode bit (1 = run, 0 = stop). It is readable and writable, and the other bits at that address read as 0.
- R10: Channels are independent: an event on one input sets only its own status bit.
- R11: Reads of any address other than 0 and 1 return 0. At address 0, the bits above 2*N_CH-1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sense | input | N_CH | Asynchronous external sense inputs |
| ext_enable | output | N_CH | External enable outputs |
| irq | output | 1 | Interrupt request, high while any status bit is set |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |

## Verification
A qualifier counter that is off by one shows up at the ports as a status bit that a pulse of QUAL_CYC-1 cycles sets, or that a pulse of QUAL_CYC cycles misses. It becomes visible on the first read a few cycles after the pulse. A qualifier that does not re-arm correctly shows up as a bit that comes back after a clear while the pin is still held high, or as a bit that a second pulse never sets. Write-one-to-clear and set-priority errors show up as a wrong readback on the read that follows the write. A stuck interrupt, enable or mode flop shows as soon as `irq`, `ext_enable` or the read data is sampled after the next write.

// File: rtl/sense_pkg.sv
package sense_pkg;
   // Register addresses on the control bus
   localparam int unsigned ADDR_USER = 0;
   localparam int unsigned ADDR_MODE = 1;
   // Bit position of the run flag at ADDR_MODE
   localparam int unsigned MODE_RUN_BIT = 0;
endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sense_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sense_qualify.sv
module sense_qualify #(
   parameter int QUAL_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   output logic fire
);
   if (QUAL_CYC < 1) begin : g_bad_qual
      $error("sense_qualify: QUAL_CYC must be at least 1");
   end

   if (QUAL_CYC == 1) begin : g_edge
      // Single-cycle qualification: one pulse on each rising edge
      logic s_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_d <= 1'b0;
         else        s_d <= s;
      end
      assign fire = s & ~s_d;
   end else begin : g_count
      localparam int CW = $clog2(QUAL_CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);
      localparam logic [CW-1:0] SAT  = CW'(QUAL_CYC);
      logic [CW-1:0] cnt;
      // The count saturates past LAST, so fire comes once per high period
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (!s)         cnt <= '0;
         else if (cnt != SAT) cnt <= cnt + 1'b1;
      end
      assign fire = s && (cnt == LAST);
   end
endmodule

// File: rtl/sense_latch_regs.sv
module sense_latch_regs #(
   parameter int N_CH        = 2,
   parameter int QUAL_CYC    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ext_sense,
   output logic [N_CH-1:0]   ext_enable,
   output logic              irq,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   import sense_pkg::*;

   localparam int EN_LO = N_CH;
   localparam int EN_HI = 2 * N_CH - 1;

   if (N_CH < 1 || 2 * N_CH > DATA_W) begin : g_bad_width
      $error("sense_latch_regs: 2*N_CH must fit in DATA_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sense_latch_regs: ADDR_W must be at least 1");
   end

   logic [N_CH-1:0] fire;
   logic [N_CH-1:0] sense_q;
   logic [N_CH-1:0] enable_q;
   logic            run_mode;
   logic            wr_user;
   logic            wr_mode;

   assign wr_user = bus_wr && (bus_addr == ADDR_W'(ADDR_USER));
   assign wr_mode = bus_wr && (bus_addr == ADDR_W'(ADDR_MODE));

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic s_sync;
      sense_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (ext_sense[i]),
         .q    (s_sync)
      );
      sense_qualify #(.QUAL_CYC(QUAL_CYC)) i_qual (
         .clk  (clk),
         .rst_n(rst_n),
         .s    (s_sync),
         .fire (fire[i])
      );
      // A qualification wins over a clearing write in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sense_q[i] <= 1'b0;
         else if (fire[i]) sense_q[i] <= 1'b1;
         else if (wr_user && bus_wdata[i]) sense_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         run_mode <= 1'b0;
      end else begin
         if (wr_user) enable_q <= bus_wdata[EN_HI:EN_LO];
         if (wr_mode) run_mode <= bus_wdata[MODE_RUN_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_USER)) begin
         bus_rdata[N_CH-1:0]   = sense_q;
         bus_rdata[EN_HI:EN_LO] = enable_q;
      end else if (bus_addr == ADDR_W'(ADDR_MODE)) begin
         bus_rdata[MODE_RUN_BIT] = run_mode;
      end
   end

   assign ext_enable = enable_q;
   assign irq        = |sense_q;
endmodule

// File: rtl/sense_latch_regs_chk.sv
module sense_latch_regs_chk #(
   parameter int N_CH   = 2,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [N_CH-1:0]   fire,
   input logic [N_CH-1:0]   sense_q,
   input logic [N_CH-1:0]   ext_enable,
   input logic              irq,
   input logic              run_mode
);
   logic            user_wr;
   logic            mode_wr;
   logic [N_CH-1:0] keep;

   assign user_wr = bus_wr && (bus_addr == ADDR_W'(sense_pkg::ADDR_USER));
   assign mode_wr = bus_wr && (bus_addr == ADDR_W'(sense_pkg::ADDR_MODE));
   assign keep    = user_wr ? ~bus_wdata[N_CH-1:0] : {N_CH{1'b1}};

   // R2
   set_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_q & ~$past(sense_q) & ~$past(fire)) == '0));

   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fire) |=> ((sense_q & $past(fire)) == $past(fire)));

   // R3
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sense_q & keep)) |=> ((sense_q & $past(sense_q & keep)) == $past(sense_q & keep)));

   // R8
   enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      user_wr |=> (ext_enable == $past(bus_wdata[2*N_CH-1:N_CH])));

   // R7
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|fire));

   // R7
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(user_wr));

   // R9
   mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(run_mode));
endmodule

bind sense_latch_regs sense_latch_regs_chk #(
   .N_CH  (N_CH),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .fire      (fire),
   .sense_q   (sense_q),
   .ext_enable(ext_enable),
   .irq       (irq),
   .run_mode  (run_mode)
);

// File: tb/test_sense_latch_regs.sv
`timescale 1ns/1ps
module test_sense_latch_regs;
   localparam int N_CH = 2;
   localparam int QUAL = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_sense = '0;
   logic [1:0] ext_enable;
   logic       irq;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sense_latch_regs #(.N_CH(N_CH), .QUAL_CYC(QUAL)) i_sense_latch_regs (
      .clk(clk), .rst_n(rst_n), .ext_sense(ext_sense), .ext_enable(ext_enable),
      .irq(irq), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   task automatic check(string req, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // Drive a sense input high for exactly 'cyc' rising edges, then settle
   task automatic pulse(int ch, int cyc);
      @(negedge clk);
      ext_sense[ch] = 1'b1;
      repeat (cyc) @(negedge clk);
      ext_sense[ch] = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_read(0, d); check("R1 user reg in reset", d, 0);
      bus_read(1, d); check("R1 mode reg in reset", d, 0);
      check("R1 irq in reset", irq, 0);
      check("R1 enables in reset", ext_enable, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_short_pulse();
      logic [7:0] d;
      pulse(0, QUAL - 1);
      bus_read(0, d); check("R2 short pulse ignored", d, 0);
      check("R7 irq low after short pulse", irq, 0);
   endtask

   task automatic t_long_pulse();
      logic [7:0] d;
      pulse(0, QUAL);
      bus_read(0, d); check("R2 qualified pulse sets bit0", d, 1);
      check("R3 bit held after input low", ext_sense[0], 0);
      check("R7 irq high with bit set", irq, 1);
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      bus_write(0, 8'h00);
      bus_read(0, d); check("R4 zero write keeps bit", d, 1);
      bus_write(0, 8'h01);
      bus_read(0, d); check("R4 one write clears bit", d, 0);
      check("R7 irq low after clear", irq, 0);
   endtask

   task automatic t_independent();
      logic [7:0] d;
      pulse(1, QUAL + 2);
      bus_read(0, d); check("R10 ch1 sets only bit1", d, 2);
      bus_write(0, 8'h01);
      bus_read(0, d); check("R10 clearing bit0 leaves bit1", d, 2);
      bus_write(0, 8'h02);
      bus_read(0, d); check("R4 bit1 cleared", d, 0);
   endtask

   task automatic t_rearm();
      logic [7:0] d;
      @(negedge clk); ext_sense[0] = 1'b1;
      repeat (10) @(negedge clk);
      bus_read(0, d); check("R6 held input sets bit", d, 1);
      bus_write(0, 8'h01);
      repeat (10) @(negedge clk);
      bus_read(0, d); check("R6 held input does not re-set", d, 0);
      ext_sense[0] = 1'b0;
      repeat (4) @(negedge clk);
      pulse(0, QUAL + 2);
      bus_read(0, d); check("R6 re-qualified input sets bit", d, 1);
      bus_write(0, 8'h01);
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      pulse(0, QUAL + 1);
      bus_read(0, d); check("R5 precondition bit set", d, 1);
      @(negedge clk); ext_sense[0] = 1'b1;
      // two sync edges plus QUAL counting edges: fire lands in this cycle
      repeat (1 + QUAL) @(negedge clk);
      bus_wr = 1'b1; bus_addr = 0; bus_wdata = 8'h01;
      @(negedge clk); bus_wr = 1'b0;
      ext_sense[0] = 1'b0;
      repeat (4) @(negedge clk);
      bus_read(0, d); check("R5 set beats clear", d, 1);
      bus_write(0, 8'h01);
      bus_read(0, d); check("R5 later clear works", d, 0);
   endtask

   task automatic t_enables();
      logic [7:0] d;
      bus_write(0, 8'h04);
      #1 check("R8 ext_enable 01", ext_enable, 1);
      bus_read(0, d); check("R8 readback enable0", d, 8'h04);
      bus_write(0, 8'h08);
      #1 check("R8 ext_enable 10", ext_enable, 2);
      bus_write(0, 8'hFC);
      #1 check("R8 ext_enable 11", ext_enable, 3);
      bus_read(0, d); check("R11 upper bits read zero", d, 8'h0C);
      check("R8 enable write leaves irq low", irq, 0);
      bus_write(0, 8'h00);
      #1 check("R8 ext_enable cleared", ext_enable, 0);
   endtask

   task automatic t_mode();
      logic [7:0] d;
      bus_write(1, 8'hFF);
      bus_read(1, d); check("R9 mode run, other bits zero", d, 1);
      bus_read(2, d); check("R11 unmapped address reads zero", d, 0);
      bus_read(3, d); check("R11 unmapped address 3 reads zero", d, 0);
      bus_write(1, 8'h00);
      bus_read(1, d); check("R9 mode back to stop", d, 0);
   endtask

   task automatic t_reset_midrun();
      logic [7:0] d;
      bus_write(1, 8'h01);
      bus_write(0, 8'h0C);
      pulse(1, QUAL);
      bus_read(0, d); check("R1 precondition", d, 8'h0E);
      @(negedge clk); rst_n = 1'b0;
      #1 check("R1 enables cleared by reset", ext_enable, 0);
      check("R1 irq cleared by reset", irq, 0);
      bus_read(0, d); check("R1 user reg cleared by reset", d, 0);
      bus_read(1, d); check("R1 mode stop after reset", d, 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      t_reset();
      t_short_pulse();
      t_long_pulse();
      t_w1c();
      t_independent();
      t_rearm();
      t_set_wins();
      t_enables();
      t_mode();
      t_reset_midrun();
      done = 1;
      finish_run();
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule